// File: doc/BRIEF.md
# Cascading Interrupt Aggregator with Direct Routing

This block collects up to 32 level-sensitive interrupt sources and presents them to a primary interrupt controller in two ways. By default every enabled, asserted source is folded into one cascade line, which the chip wires to the primary controller's input 31. Sources in the upper range can instead be steered onto a direct line with the same number, so the primary controller sees them without the software having to look through this block first.

Software owns three pieces of state through a small word-addressed register bus. The enable mask is changed only through two write ports: one sets bits and the other clears them, so concurrent agents never need a read-modify-write. A pass-through selection chooses which upper sources take the direct path. A masked status word reports which enabled sources are currently asserted, whatever route they take. All outputs, including read data, come from flops and change one clock after their inputs.

Register word index (`bus_addr`): 0 = masked status (read only), 1 = enable set (a read returns the enable mask), 2 = enable clear (write only), 3 = pass-through selection. Other indices read as 0 and ignore writes.

Top module: `sic_route_ctrl`

## Requirements
- R1: After reset the enable mask and the pass-through selection are all zero, `cascade_irq` and `direct_irq` are 0, and every register reads as 0 while no source is asserted.
- R2: A write to index 1 sets the enable bit of each source whose data bit is 1 and leaves every other enable bit unchanged; a read of index 1 returns the enable mask.
- R3: A write to index 2 clears the enable bit of each source whose data bit is 1 and leaves the others unchanged; writing all ones disables every source.
- R4: A read of index 0 returns the source levels ANDed with the enable mask, as sampled on the clock edge that captures the read.
- R5: `cascade_irq` is 1 exactly when some source is asserted, enabled and not selected for pass-through.
- R6: `direct_irq[i]` equals the level of source i when source i is selected for pass-through and is 0 otherwise; the direct path does not depend on the enable mask.
- R7: Only sources 21 to 31 can be selected for pass-through; selection bits 0 to 20 ignore writes and read as 0, so writing 0xFFFFFFFF reads back 0xFFE00000 and writing 0xFFD00000 reads back 0xFFC00000.
- R8: A source selected for pass-through still shows in the status word when it is enabled and asserted.
- R9: Index 2 reads as 0, and a write to index 0 has no effect on the enable mask or the pass-through selection.
- R10: A change of a source level appears on `cascade_irq` and `direct_irq` one clock edge later, and a register write affects the outputs from the edge after the one that captures it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a two-stage synchronizer |
| src_lvl | input | 32 | Level-sensitive interrupt sources, synchronous to clk |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 for a write, 0 for a read while bus_sel is 1 |
| bus_addr | input | 4 | Register word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered, valid the cycle after a read strobe |
| cascade_irq | output | 1 | Combined line to primary controller input 31 |
| direct_irq | output | 32 | Per-source direct lines to the primary controller |

## Verification
The bench builds the block with its default parameters: 32 sources, pass-through starting at source 21 and a four-bit address. With that setting the boundary between bit 20 and bit 21 of the selection word is reachable, so a full-ones write and the 0xFFD00000 pattern both show which bits are kept. Unused upper address bits also exist, so the decode of index 0 versus the other indices is exercised with full-width words.

// File: rtl/sic_pkg.sv
package sic_pkg;
  typedef enum logic [1:0] {
    IDX_STATUS = 2'd0,
    IDX_EN_SET = 2'd1,
    IDX_EN_CLR = 2'd2,
    IDX_PASS   = 2'd3
  } sic_idx_e;
endpackage

// File: rtl/sic_en_reg.sv
module sic_en_reg #(
  parameter int NUM_SRC = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               set_we,
  input  logic               clr_we,
  input  logic [NUM_SRC-1:0] wdata,
  output logic [NUM_SRC-1:0] en_q
);
  logic [NUM_SRC-1:0] en_d;
  logic               en_ce;

  always_comb begin
    en_ce = set_we | clr_we;
    en_d  = en_q;
    if (set_we) en_d = en_d | wdata;
    if (clr_we) en_d = en_d & ~wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= '0;
    else if (en_ce) en_q <= en_d;
  end

  // R2: bits written as one are set afterwards
  p_set_bits_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (set_we && !clr_we) |=> ((en_q & $past(wdata)) == $past(wdata)));

  // R3: bits written as one are clear afterwards
  p_clr_bits_r3: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we |=> ((en_q & $past(wdata)) == '0));

  // R2/R3: no write, no change
  p_hold_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_we && !clr_we) |=> $stable(en_q));
endmodule

// File: rtl/sic_pass_reg.sv
module sic_pass_reg #(
  parameter int NUM_SRC = 32,
  parameter int PASS_LO = 21
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [NUM_SRC-1:0] wdata,
  output logic [NUM_SRC-1:0] pt_q
);
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
    if (i < PASS_LO) begin : g_fixed
      assign pt_q[i] = 1'b0;
    end else begin : g_flop
      logic bit_d;
      logic bit_q;
      always_comb bit_d = wdata[i];
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  bit_q <= 1'b0;
        else if (we) bit_q <= bit_d;
      end
      assign pt_q[i] = bit_q;
    end
  end

  // R7/R9: selection only moves on its own write
  p_pass_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(pt_q));
endmodule

// File: rtl/sic_route.sv
module sic_route #(
  parameter int NUM_SRC = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src,
  input  logic [NUM_SRC-1:0] en,
  input  logic [NUM_SRC-1:0] pt,
  output logic [NUM_SRC-1:0] status,
  output logic               cascade_q,
  output logic [NUM_SRC-1:0] direct_q
);
  logic               cascade_d;
  logic [NUM_SRC-1:0] direct_d;

  always_comb begin
    status    = src & en;
    cascade_d = |(status & ~pt);
    direct_d  = src & pt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cascade_q <= 1'b0;
      direct_q  <= '0;
    end else begin
      cascade_q <= cascade_d;
      direct_q  <= direct_d;
    end
  end

  // R5: the cascade line needs an enabled asserted source one edge earlier
  p_cascade_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cascade_q |-> $past(|(src & en)));

  // R6: a direct line needs its selection bit and its source one edge earlier
  p_direct_route_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((direct_q & ~($past(pt) & $past(src))) == '0));
endmodule

// File: rtl/sic_route_ctrl.sv
module sic_route_ctrl #(
  parameter int NUM_SRC = 32,
  parameter int PASS_LO = 21,
  parameter int ADDR_W  = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_lvl,
  input  logic               bus_sel,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [NUM_SRC-1:0] bus_wdata,
  output logic [NUM_SRC-1:0] bus_rdata,
  output logic               cascade_irq,
  output logic [NUM_SRC-1:0] direct_irq
);
  import sic_pkg::*;

  localparam int IDX_W = 2;

  logic               rst_meta_q;
  logic               rst_sync_n;
  logic               hi_zero;
  sic_idx_e           idx;
  logic               wr_set;
  logic               wr_clr;
  logic               wr_pass;
  logic               rd_ce;
  logic [NUM_SRC-1:0] en_q;
  logic [NUM_SRC-1:0] pt_q;
  logic [NUM_SRC-1:0] status;
  logic [NUM_SRC-1:0] rdata_d;

  // Reset: asserted at once, released after two edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  // Address decode
  always_comb begin
    hi_zero = (bus_addr[ADDR_W-1:IDX_W] == '0);
    idx     = sic_idx_e'(bus_addr[IDX_W-1:0]);
    wr_set  = bus_sel && bus_wr && hi_zero && (idx == IDX_EN_SET);
    wr_clr  = bus_sel && bus_wr && hi_zero && (idx == IDX_EN_CLR);
    wr_pass = bus_sel && bus_wr && hi_zero && (idx == IDX_PASS);
    rd_ce   = bus_sel && !bus_wr;
  end

  sic_en_reg #(.NUM_SRC(NUM_SRC)) u_en (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .set_we (wr_set),
    .clr_we (wr_clr),
    .wdata  (bus_wdata),
    .en_q   (en_q)
  );

  sic_pass_reg #(.NUM_SRC(NUM_SRC), .PASS_LO(PASS_LO)) u_pass (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .we    (wr_pass),
    .wdata (bus_wdata),
    .pt_q  (pt_q)
  );

  sic_route #(.NUM_SRC(NUM_SRC)) u_route (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .src       (src_lvl),
    .en        (en_q),
    .pt        (pt_q),
    .status    (status),
    .cascade_q (cascade_irq),
    .direct_q  (direct_irq)
  );

  // Read data mux and register
  always_comb begin
    rdata_d = '0;
    if (hi_zero) begin
      unique case (idx)
        IDX_STATUS: rdata_d = status;
        IDX_EN_SET: rdata_d = en_q;
        IDX_EN_CLR: rdata_d = '0;
        IDX_PASS:   rdata_d = pt_q;
        default:    rdata_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) bus_rdata <= '0;
    else if (rd_ce)  bus_rdata <= rdata_d;
  end

  // R9: the clear port reads as zero
  p_clr_reads_zero_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_sel && !bus_wr && bus_addr == ADDR_W'(IDX_EN_CLR)) |=> (bus_rdata == '0));

  // R9: a status write leaves the mask and selection untouched
  p_status_wr_ignored_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_sel && bus_wr && bus_addr == ADDR_W'(IDX_STATUS)) |=> ($stable(en_q) && $stable(pt_q)));

  // R7: low selection bits never reach the direct lines
  p_low_direct_zero_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    direct_irq[PASS_LO-1:0] == '0);
endmodule

// File: tb/test_sic_route_ctrl.sv
module test_sic_route_ctrl;
  localparam int N  = 32;
  localparam int LO = 21;
  localparam int AW = 4;

  localparam logic [AW-1:0] A_STAT = 4'd0;
  localparam logic [AW-1:0] A_SET  = 4'd1;
  localparam logic [AW-1:0] A_CLR  = 4'd2;
  localparam logic [AW-1:0] A_PASS = 4'd3;

  logic          clk;
  logic          rst_n;
  logic [N-1:0]  src_lvl;
  logic          bus_sel;
  logic          bus_wr;
  logic [AW-1:0] bus_addr;
  logic [N-1:0]  bus_wdata;
  logic [N-1:0]  bus_rdata;
  logic          cascade_irq;
  logic [N-1:0]  direct_irq;

  sic_route_ctrl #(.NUM_SRC(N), .PASS_LO(LO), .ADDR_W(AW)) i_sic_route_ctrl (
    .clk(clk), .rst_n(rst_n), .src_lvl(src_lvl),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cascade_irq(cascade_irq), .direct_irq(direct_irq)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  typedef struct {
    int          due;
    int          kind;   // 0 rdata, 1 cascade, 2 direct
    logic [N-1:0] exp;
    string       req;
  } exp_t;

  exp_t q[$];
  int cyc = 0;
  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [N-1:0] m_en, m_pt, m_src;
  localparam logic [N-1:0] PASS_MASK = ~((N'(1) << LO) - N'(1));

  always @(posedge clk) cyc <= cyc + 1;

  // Monitor: compare every item due at this sampling point
  initial begin
    forever begin
      @(negedge clk);
      while (q.size() > 0 && q[0].due <= cyc) begin
        exp_t e;
        logic [N-1:0] act;
        e = q.pop_front();
        case (e.kind)
          0: act = bus_rdata;
          1: act = {{(N-1){1'b0}}, cascade_irq};
          default: act = direct_irq;
        endcase
        n_cmp++;
        if (e.due != cyc || act !== e.exp) begin
          n_bad++;
          $display("FAIL %s kind=%0d actual=%h expected=%h", e.req, e.kind, act, e.exp);
        end
      end
    end
  end

  function automatic logic [N-1:0] exp_read(logic [AW-1:0] a);
    case (a)
      A_STAT:  return m_src & m_en;
      A_SET:   return m_en;
      A_PASS:  return m_pt;
      default: return '0;
    endcase
  endfunction

  task automatic push(int kind, logic [N-1:0] e, string r);
    exp_t it;
    it.due = cyc + 1; it.kind = kind; it.exp = e; it.req = r;
    q.push_back(it);
  endtask

  task automatic wr(logic [AW-1:0] a, logic [N-1:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    case (a)
      A_SET:  m_en = m_en | d;
      A_CLR:  m_en = m_en & ~d;
      A_PASS: m_pt = d & PASS_MASK;
      default: ;
    endcase
  endtask

  task automatic rd(logic [AW-1:0] a, string r);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    push(0, exp_read(a), r);
  endtask

  // Drive sources and expect the outputs exactly one edge later (R10)
  task automatic src_chk(logic [N-1:0] v, string r);
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
    src_lvl = v; m_src = v;
    push(1, {{(N-1){1'b0}}, |(m_src & m_en & ~m_pt)}, r);
    push(2, m_src & m_pt, r);
  endtask

  task automatic idle();
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; src_lvl = '0; bus_sel = 1'b0; bus_wr = 1'b0;
    bus_addr = '0; bus_wdata = '0;
    m_en = '0; m_pt = '0; m_src = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    src_chk('0, "R1");
    rd(A_STAT, "R1"); rd(A_SET, "R1"); rd(A_PASS, "R1");

    // R2 set semantics
    wr(A_SET, 32'h0000_00F0); rd(A_SET, "R2");
    wr(A_SET, 32'h0000_0001); rd(A_SET, "R2");
    // R3 clear semantics, R9 clear address reads 0
    wr(A_CLR, 32'h0000_0030); rd(A_SET, "R3");
    rd(A_CLR, "R9");

    // R4 status, R5 cascade, R10 latency
    src_chk(32'hFFFF_FFFF, "R5");
    rd(A_STAT, "R4");
    src_chk(32'h0000_0100, "R5");
    rd(A_STAT, "R4");
    src_chk(32'h0000_0040, "R10");
    src_chk(32'h0000_0000, "R10");

    // R7 selection readback
    wr(A_PASS, 32'hFFFF_FFFF); rd(A_PASS, "R7");
    wr(A_PASS, 32'hFFD0_0000); rd(A_PASS, "R7");

    // R8 / R6: routed source still in status, not on cascade
    wr(A_SET, 32'h0200_0000);
    src_chk(32'h0200_0000, "R6");
    rd(A_STAT, "R8");
    // bit 21 not routable by 0xFFD00000 -> cascade; bit 20 dropped -> cascade
    wr(A_SET, 32'h0030_0000);
    src_chk(32'h0020_0000, "R7");
    src_chk(32'h0010_0000, "R7");
    // R6: direct path ignores the enable mask
    src_chk(32'h4000_0000, "R6");
    rd(A_STAT, "R6");

    // R9 status write ignored
    wr(A_STAT, 32'hFFFF_FFFF);
    rd(A_SET, "R9"); rd(A_PASS, "R9");

    // R3 clear all
    wr(A_CLR, 32'hFFFF_FFFF); rd(A_SET, "R3");
    src_chk(32'hFFFF_FFFF, "R3");
    rd(A_STAT, "R3");

    // R10: register write reaches outputs on the following edge
    wr(A_PASS, 32'h0000_0000);
    wr(A_SET, 32'h0000_0001);
    src_chk(32'h0000_0001, "R10");
    idle(); idle();
    while (q.size() > 0) @(negedge clk);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule